// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Interrupts

This block sits between a host register interface and the shift engine of a serial peripheral. It holds two byte queues. The transmit queue is filled by the host and emptied by the engine. The receive queue is filled by the engine and emptied by the host. Each queue has an 8-bit programmable trigger level, and its occupancy is visible in a status word. Software can use these to move data in bursts instead of byte by byte.

Four event flags are kept in a sticky status word: receive ready, transmit request, receive overflow and transfer complete. Each flag is cleared by writing 1 to its bit. A flag that qualifies again in the same cycle as its clear stays set, so an event that arrives while software is servicing the previous one is not lost. The interrupt line is the OR of the flags that are enabled. The engine side is reduced to pop and push strobes plus a completion pulse. The shifter itself and the address decoding are not part of the block.

Top module: `thr_fifo_pair`

## Requirements
- R1: While `rst` is high, and in the first sample after reset, both occupancies are 0, the status word is 0, the enables are 0, the trigger levels read back as 0 and `irq` is 0.
- R2: Bytes leave each queue in the order they entered. Read data (`rx_rdata` for `rx_rd`, `eng_tx_data` for `eng_tx_pop`) is registered and valid in the cycle after the strobe. It holds its value until the next strobe.
- R3: `fifo_stat` carries the receive occupancy in bits [CW-1:0] and the transmit occupancy in bits [16+CW-1:16], with CW = clog2(DEPTH+1) (7 for the default depth of 64). All other bits are 0. An occupancy never exceeds DEPTH.
- R4: In the control word, bits [7:0] hold the receive trigger level and bits [23:16] hold the transmit trigger level. Both read back on `ctl_q`. Writing 1 to bit 15 empties the receive queue and writing 1 to bit 31 empties the transmit queue, and both may be requested in one write. The flush bits read back as 0. A flush takes precedence over a push or pop in the same cycle.
- R5: Status bit 0 (receive ready) sets one cycle after the receive occupancy becomes greater than or equal to the receive trigger level.
- R6: Status bit 4 (transmit request) sets one cycle after the transmit occupancy becomes less than or equal to the transmit trigger level.
- R7: Status bit 8 (receive overflow) sets at the clock edge where the engine pushes into a full receive queue. The pushed byte is dropped and the stored bytes are kept.
- R8: Status bit 12 (transfer complete) sets at the clock edge where `xfer_done` is high.
- R9: A status bit clears only when 1 is written to it through `ist_we`. Writing 0 has no effect, and writing all ones clears every flag whose condition is false. If a flag's set condition is true in the same cycle as its clear, the flag stays set.
- R10: Only enable bits 0, 4, 8 and 12 are stored. `irq` equals the OR of (status AND enable) and changes in the same cycle as the status word.
- R11: Reading an empty receive queue returns 0 and leaves its occupancy unchanged. An engine pop of an empty transmit queue returns 0. A host write into a full transmit queue is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word value: trigger levels and flush bits |
| ctl_q | output | 32 | Control word read-back |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 32 | Interrupt enable value |
| ien_q | output | 32 | Stored interrupt enables |
| ist_we | input | 1 | Status write-one-to-clear strobe |
| ist_wdata | input | 32 | Status bits to clear |
| ist_q | output | 32 | Sticky interrupt status |
| fifo_stat | output | 32 | Occupancy of both queues |
| tx_wr | input | 1 | Host writes a transmit byte |
| tx_wdata | input | 8 | Transmit byte from host |
| rx_rd | input | 1 | Host reads a receive byte |
| rx_rdata | output | 8 | Receive byte to host, valid the cycle after `rx_rd` |
| eng_tx_pop | input | 1 | Engine takes a transmit byte |
| eng_tx_data | output | 8 | Transmit byte to engine, valid the cycle after the pop |
| eng_rx_push | input | 1 | Engine delivers a receive byte |
| eng_rx_data | input | 8 | Receive byte from engine |
| xfer_done | input | 1 | Transfer-complete pulse from engine |
| irq | output | 1 | Interrupt request |

## Verification
Short bursts with distinct byte values on each side check the ordering and the occupancy fields. A full fill of the receive queue followed by one extra push shows that the overflowing byte is dropped, because the readback still matches the original sequence. The thresholds are approached one byte at a time, so a flag that appears one cycle early or late, or that uses the wrong comparison direction, is caught. The clear tests write zeros, write single bits, write all ones, and raise an event in the same cycle as its clear, which together separate a proper write-one-to-clear from a plain register write.

// File: rtl/thr_fifo_pkg.sv
package thr_fifo_pkg;
  // Event flags sit every FLAG_STRIDE bits, starting at bit 0.
  localparam int NFLAG        = 4;
  localparam int FLAG_STRIDE  = 4;
  localparam int FLG_RXRDY    = 0;
  localparam int FLG_TXREQ    = 1;
  localparam int FLG_RXOVF    = 2;
  localparam int FLG_DONE     = 3;

  // Control word layout
  localparam int TRIG_W       = 8;
  localparam int CTL_RXTRIG_LSB = 0;
  localparam int CTL_RXFLUSH  = 15;
  localparam int CTL_TXTRIG_LSB = 16;
  localparam int CTL_TXFLUSH  = 31;

  // Status word layout
  localparam int STAT_TX_LSB  = 16;

  function automatic int flag_bit(input int idx);
    return idx * FLAG_STRIDE;
  endfunction
endpackage

// File: rtl/byte_ring.sv
module byte_ring #(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          pop,
  output logic [7:0]    dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign count   = cnt;

  // Storage without reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      dout <= '0;
    end else begin
      if (pop) dout <= pop_ok ? mem[rptr] : 8'h00;
      if (flush) begin
        wptr <= '0;
        rptr <= '0;
        cnt  <= '0;
      end else begin
        if (push_ok) wptr <= adv(wptr);
        if (pop_ok)  rptr <= adv(rptr);
        case ({push_ok, pop_ok})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end
  end
endmodule

// File: rtl/fifo_ctl.sv
module fifo_ctl
  import thr_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [31:0]       ctl_wdata,
  output logic [TRIG_W-1:0] rx_trig,
  output logic [TRIG_W-1:0] tx_trig,
  output logic              rx_flush,
  output logic              tx_flush,
  output logic [31:0]       ctl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_trig <= '0;
      tx_trig <= '0;
    end else if (ctl_we) begin
      rx_trig <= ctl_wdata[CTL_RXTRIG_LSB +: TRIG_W];
      tx_trig <= ctl_wdata[CTL_TXTRIG_LSB +: TRIG_W];
    end
  end

  // Flush bits act as pulses in the write cycle and are not stored.
  assign rx_flush = ctl_we && ctl_wdata[CTL_RXFLUSH];
  assign tx_flush = ctl_we && ctl_wdata[CTL_TXFLUSH];

  always_comb begin
    ctl_q = '0;
    ctl_q[CTL_RXTRIG_LSB +: TRIG_W] = rx_trig;
    ctl_q[CTL_TXTRIG_LSB +: TRIG_W] = tx_trig;
  end
endmodule

// File: rtl/irq_status.sv
module irq_status
  import thr_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_ev,
  input  logic             ist_we,
  input  logic [31:0]      ist_wdata,
  input  logic             ien_we,
  input  logic [31:0]      ien_wdata,
  output logic [31:0]      ist_q,
  output logic [31:0]      ien_q,
  output logic             irq
);
  logic [NFLAG-1:0] flag_q, flag_d, en_q, en_d;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    localparam int BIT = flag_bit(i);
    logic clr;
    assign clr       = ist_we && ist_wdata[BIT];
    // A new event wins over a clear in the same cycle.
    assign flag_d[i] = set_ev[i] | (flag_q[i] & ~clr);
    assign en_d[i]   = ien_we ? ien_wdata[BIT] : en_q[i];
    assign ist_q[BIT] = flag_q[i];
    assign ien_q[BIT] = en_q[i];
    for (genvar j = 1; j < FLAG_STRIDE; j++) begin : g_pad
      assign ist_q[BIT + j] = 1'b0;
      assign ien_q[BIT + j] = 1'b0;
    end
  end

  for (genvar k = NFLAG * FLAG_STRIDE; k < 32; k++) begin : g_hi
    assign ist_q[k] = 1'b0;
    assign ien_q[k] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
      irq    <= 1'b0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      irq    <= |(flag_d & en_d);
    end
  end
endmodule

// File: rtl/thr_fifo_pair.sv
module thr_fifo_pair
  import thr_fifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_q,
  input  logic        ien_we,
  input  logic [31:0] ien_wdata,
  output logic [31:0] ien_q,
  input  logic        ist_we,
  input  logic [31:0] ist_wdata,
  output logic [31:0] ist_q,
  output logic [31:0] fifo_stat,
  input  logic        tx_wr,
  input  logic [7:0]  tx_wdata,
  input  logic        rx_rd,
  output logic [7:0]  rx_rdata,
  input  logic        eng_tx_pop,
  output logic [7:0]  eng_tx_data,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_data,
  input  logic        xfer_done,
  output logic        irq
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int CMPW = (CW > TRIG_W) ? CW : TRIG_W;

  logic [TRIG_W-1:0] rx_trig, tx_trig;
  logic              rx_flush, tx_flush;
  logic [CW-1:0]     rx_cnt, tx_cnt;
  logic              rx_full, rx_empty, tx_full, tx_empty;
  logic [NFLAG-1:0]  set_ev;

  fifo_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .ctl_we   (ctl_we),
    .ctl_wdata(ctl_wdata),
    .rx_trig  (rx_trig),
    .tx_trig  (tx_trig),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush),
    .ctl_q    (ctl_q)
  );

  byte_ring #(.DEPTH(DEPTH)) u_txq (
    .clk  (clk),
    .rst  (rst),
    .flush(tx_flush),
    .push (tx_wr),
    .din  (tx_wdata),
    .pop  (eng_tx_pop),
    .dout (eng_tx_data),
    .count(tx_cnt),
    .full (tx_full),
    .empty(tx_empty)
  );

  byte_ring #(.DEPTH(DEPTH)) u_rxq (
    .clk  (clk),
    .rst  (rst),
    .flush(rx_flush),
    .push (eng_rx_push),
    .din  (eng_rx_data),
    .pop  (rx_rd),
    .dout (rx_rdata),
    .count(rx_cnt),
    .full (rx_full),
    .empty(rx_empty)
  );

  // Threshold events from the registered occupancies.
  always_comb begin
    set_ev            = '0;
    set_ev[FLG_RXRDY] = CMPW'(rx_cnt) >= CMPW'(rx_trig);
    set_ev[FLG_TXREQ] = CMPW'(tx_cnt) <= CMPW'(tx_trig);
    set_ev[FLG_RXOVF] = eng_rx_push && rx_full;
    set_ev[FLG_DONE]  = xfer_done;
  end

  irq_status u_irq (
    .clk      (clk),
    .rst      (rst),
    .set_ev   (set_ev),
    .ist_we   (ist_we),
    .ist_wdata(ist_wdata),
    .ien_we   (ien_we),
    .ien_wdata(ien_wdata),
    .ist_q    (ist_q),
    .ien_q    (ien_q),
    .irq      (irq)
  );

  always_comb begin
    fifo_stat = '0;
    fifo_stat[CW-1:0]            = rx_cnt;
    fifo_stat[STAT_TX_LSB +: CW] = tx_cnt;
  end
endmodule

// File: rtl/thr_fifo_pair_chk.sv
module thr_fifo_pair_chk #(
  parameter int DEPTH = 64
) (
  input logic        clk,
  input logic        rst,
  input logic        ctl_we,
  input logic [31:0] ctl_wdata,
  input logic        ist_we,
  input logic [31:0] ist_wdata,
  input logic [31:0] ist_q,
  input logic [31:0] ien_q,
  input logic [31:0] fifo_stat,
  input logic        rx_rd,
  input logic [7:0]  rx_rdata,
  input logic        eng_rx_push,
  input logic        xfer_done,
  input logic        irq
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] rxc, txc;
  assign rxc = fifo_stat[CW-1:0];
  assign txc = fifo_stat[16 +: CW];

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (rxc <= CW'(DEPTH)) && (txc <= CW'(DEPTH)));

  assert_rx_flush_R4: assert property (@(posedge clk) disable iff (rst)
    ctl_we && ctl_wdata[15] |=> rxc == '0);

  assert_tx_flush_R4: assert property (@(posedge clk) disable iff (rst)
    ctl_we && ctl_wdata[31] |=> txc == '0);

  assert_overflow_flag_R7: assert property (@(posedge clk) disable iff (rst)
    eng_rx_push && rxc == CW'(DEPTH) && !rx_rd && !(ctl_we && ctl_wdata[15])
    |=> ist_q[8] && rxc == CW'(DEPTH));

  assert_done_flag_R8: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> ist_q[12]);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ist_q[12] && !(ist_we && ist_wdata[12]) |=> ist_q[12]);

  assert_irq_or_R10: assert property (@(posedge clk) disable iff (rst)
    irq == |(ist_q & ien_q));

  assert_ien_bits_R10: assert property (@(posedge clk) disable iff (rst)
    (ien_q & ~32'h0000_1111) == '0);

  assert_empty_read_R11: assert property (@(posedge clk) disable iff (rst)
    rx_rd && rxc == '0 && !eng_rx_push |=> rx_rdata == 8'h00 && rxc == '0);
endmodule

bind thr_fifo_pair thr_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/thr_fifo_pair_test.sv
module thr_fifo_pair_test;
  localparam int DEPTH = 64;
  localparam int CW    = $clog2(DEPTH + 1);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 0, ien_we = 0, ist_we = 0;
  logic [31:0] ctl_wdata = 0, ien_wdata = 0, ist_wdata = 0;
  logic [31:0] ctl_q, ien_q, ist_q, fifo_stat;
  logic        tx_wr = 0, rx_rd = 0, eng_tx_pop = 0, eng_rx_push = 0, xfer_done = 0;
  logic [7:0]  tx_wdata = 0, eng_rx_data = 0, rx_rdata, eng_tx_data;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  thr_fifo_pair #(.DEPTH(DEPTH)) uut (.*);

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rxc();
    return fifo_stat[CW-1:0];
  endfunction
  function automatic logic [31:0] txc();
    return fifo_stat[16 +: CW];
  endfunction

  task automatic wr_ctl(input logic [31:0] v);
    ctl_we = 1; ctl_wdata = v; tick(); ctl_we = 0;
  endtask
  task automatic wr_ien(input logic [31:0] v);
    ien_we = 1; ien_wdata = v; tick(); ien_we = 0;
  endtask
  task automatic w1c(input logic [31:0] v);
    ist_we = 1; ist_wdata = v; tick(); ist_we = 0;
  endtask
  task automatic host_put(input logic [7:0] b);
    tx_wr = 1; tx_wdata = b; tick(); tx_wr = 0;
  endtask
  task automatic eng_put(input logic [7:0] b);
    eng_rx_push = 1; eng_rx_data = b; tick(); eng_rx_push = 0;
  endtask
  task automatic host_get(output logic [7:0] b);
    rx_rd = 1; tick(); rx_rd = 0; b = rx_rdata;
  endtask
  task automatic eng_get(output logic [7:0] b);
    eng_tx_pop = 1; tick(); eng_tx_pop = 0; b = eng_tx_data;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 status", ist_q, 32'h0);
    chk("R1 counts", fifo_stat, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 ctl", ctl_q, 32'h0);
    chk("R1 ien", ien_q, 32'h0);
    rst = 0;
    tick();
    chk("R1 counts after release", fifo_stat, 32'h0);
  endtask

  task automatic t_order();
    logic [7:0] b;
    host_put(8'hA1); host_put(8'hB2); host_put(8'hC3);
    chk("R3 tx count field", fifo_stat, 32'h0003_0000);
    eng_put(8'h11); eng_put(8'h22); eng_put(8'h33);
    chk("R3 both count fields", fifo_stat, 32'h0003_0003);
    eng_get(b); chk("R2 tx byte 0", b, 8'hA1);
    eng_get(b); chk("R2 tx byte 1", b, 8'hB2);
    eng_get(b); chk("R2 tx byte 2", b, 8'hC3);
    host_get(b); chk("R2 rx byte 0", b, 8'h11);
    tick(); chk("R2 rx data holds", rx_rdata, 8'h11);
    host_get(b); chk("R2 rx byte 1", b, 8'h22);
    host_get(b); chk("R2 rx byte 2", b, 8'h33);
    chk("R3 counts drained", fifo_stat, 32'h0);
  endtask

  task automatic t_ctl();
    host_put(8'h01); host_put(8'h02); eng_put(8'h03); eng_put(8'h04);
    wr_ctl(32'h8011_8025);
    chk("R4 trigger readback", ctl_q, 32'h0011_0025);
    chk("R4 dual flush", fifo_stat, 32'h0);
    host_put(8'h05); eng_put(8'h06);
    wr_ctl(32'h0011_8025);
    chk("R4 rx-only flush", fifo_stat, 32'h0001_0000);
    wr_ctl(32'h8011_0025);
    chk("R4 tx-only flush", fifo_stat, 32'h0);
    ctl_we = 1; ctl_wdata = 32'h0011_8025; eng_rx_push = 1; eng_rx_data = 8'h77;
    tick();
    ctl_we = 0; eng_rx_push = 0;
    chk("R4 flush beats push", rxc(), 32'h0);
  endtask

  task automatic t_rx_ready();
    logic [7:0] b;
    wr_ctl(32'h8000_8003);
    w1c(32'hFFFF_FFFF);
    eng_put(8'h41); eng_put(8'h42); tick();
    chk("R5 below trigger", {31'b0, ist_q[0]}, 32'h0);
    eng_put(8'h43);
    chk("R5 not yet at count edge", {31'b0, ist_q[0]}, 32'h0);
    tick();
    chk("R5 set at trigger", {31'b0, ist_q[0]}, 32'h1);
    for (int i = 0; i < 3; i++) host_get(b);
  endtask

  task automatic t_tx_req();
    logic [7:0] b;
    wr_ctl(32'h8002_8005);
    for (int i = 0; i < 4; i++) host_put(8'(8'h60 + i));
    w1c(32'hFFFF_FFFF);
    chk("R6 above trigger", {31'b0, ist_q[4]}, 32'h0);
    eng_get(b);
    chk("R6 three left", {31'b0, ist_q[4]}, 32'h0);
    eng_get(b);
    chk("R6 not yet at count edge", {31'b0, ist_q[4]}, 32'h0);
    tick();
    chk("R6 set at trigger", {31'b0, ist_q[4]}, 32'h1);
    wr_ctl(32'h8002_8005);
  endtask

  task automatic t_overflow();
    logic [7:0] b;
    wr_ctl(32'h8000_8005);
    w1c(32'hFFFF_FFFF);
    for (int i = 0; i < DEPTH; i++) eng_put(8'(i));
    chk("R7 full count", rxc(), DEPTH);
    chk("R7 no flag before overflow", {31'b0, ist_q[8]}, 32'h0);
    eng_put(8'hEE);
    chk("R7 overflow flag", {31'b0, ist_q[8]}, 32'h1);
    chk("R7 count stays full", rxc(), DEPTH);
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
        host_get(b);
        if (b !== 8'(i)) bad++;
      end
      chk("R7 stored bytes intact", bad, 0);
    end
    chk("R7 drained", rxc(), 32'h0);
  endtask

  task automatic t_w1c();
    w1c(32'hFFFF_FFFF);
    xfer_done = 1; tick(); xfer_done = 0;
    chk("R8 done flag", {31'b0, ist_q[12]}, 32'h1);
    w1c(32'h0);
    chk("R9 zero write keeps flag", {31'b0, ist_q[12]}, 32'h1);
    w1c(32'h0000_1000);
    chk("R9 one clears flag", {31'b0, ist_q[12]}, 32'h0);
    xfer_done = 1; ist_we = 1; ist_wdata = 32'h0000_1000; tick();
    xfer_done = 0; ist_we = 0;
    chk("R9 set beats clear", {31'b0, ist_q[12]}, 32'h1);
    wr_ctl(32'h8000_8005);
    host_put(8'h99);
    w1c(32'hFFFF_FFFF);
    chk("R9 all ones clears all", ist_q, 32'h0);
    tick();
    chk("R9 stays clear", ist_q, 32'h0);
  endtask

  task automatic t_irq();
    wr_ien(32'hFFFF_FFFF);
    chk("R10 enable bits stored", ien_q, 32'h0000_1111);
    chk("R10 no irq without flag", {31'b0, irq}, 32'h0);
    xfer_done = 1; tick(); xfer_done = 0;
    chk("R10 irq with flag", {31'b0, irq}, 32'h1);
    wr_ien(32'h0000_0111);
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    wr_ien(32'h0000_1000);
    chk("R10 irq unmasked", {31'b0, irq}, 32'h1);
    w1c(32'hFFFF_FFFF);
    chk("R10 irq after clear", {31'b0, irq}, 32'h0);
    wr_ien(32'h0);
    wr_ctl(32'h8000_8005);
  endtask

  task automatic t_empty();
    logic [7:0] b;
    eng_put(8'h5A);
    host_get(b); chk("R11 last byte", b, 8'h5A);
    host_get(b); chk("R11 empty read zero", b, 8'h00);
    chk("R11 count unchanged", rxc(), 32'h0);
    eng_get(b); chk("R11 empty pop zero", b, 8'h00);
    for (int i = 0; i <= DEPTH; i++) host_put(8'(i + 16));
    chk("R11 tx full count", txc(), DEPTH);
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
        eng_get(b);
        if (b !== 8'(i + 16)) bad++;
      end
      chk("R11 extra tx byte dropped", bad, 0);
    end
    eng_get(b); chk("R11 pop after drain", b, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_order();
    t_ctl();
    t_rx_ready();
    t_tx_req();
    t_overflow();
    t_w1c();
    t_irq();
    t_empty();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule